// File: doc/BRIEF.md
# Write-Protect Command Sequencer

This block guards the write path of a byte-wide nonvolatile memory. It watches a synchronously sampled memory bus (address, data and active-low chip, write and output enables) and turns each write strobe that passes qualification into one decision. The decision is one of four: pass the byte to the array, advance a command sequence, change the global protection flag, or punish the attempt with a timed lockout.

Protection is a single flag that covers every address. A three-byte prefix arms the flag and opens a page-load window. Writes that arrive while that window is open reach the array. A longer six-byte sequence clears the flag. While the flag is set, a data write without the prefix grants nothing and blocks the device for a parameterised number of clocks. During that time both reads and writes are refused.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset `prot_on`, `lockout` and `arr_wr_en` are all low.
- R2: The strobes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 (address zero-extended to `ADDR_W`, data byte) set `prot_on` and open a page-load window. The window stays open while each following write ends within `PAGE_WIN` clocks of the previous one. Each such write is granted whatever its address. The three command bytes themselves are never granted.
- R3: While unprotected, a write that is not a command byte raises `arr_wr_en` for one clock, with its address and data. The pulse comes in the cycle after the clock edge at which the strobe is seen released.
- R4: The strobes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20 clear `prot_on`. None of the six is granted.
- R5: While protected and outside an open window, a data write is not granted. It raises `lockout` for exactly `LOCK_CYC` clocks, starting in the cycle after the releasing edge.
- R6: While `lockout` is high, strobes are discarded. They neither grant a write nor advance a sequence.
- R7: A byte that does not match the next expected step abandons the partial sequence. That byte is then handled as a data write: granted if unprotected, locked out if protected.
- R8: A strobe counts only while `bus_ce_n` is low, `bus_we_n` is low and `bus_oe_n` is high.
- R9: A strobe that is qualified for fewer than `GLITCH_MIN` consecutive clocks is ignored. One of exactly `GLITCH_MIN` clocks is accepted.
- R10: Once the page-load window has expired with the flag still set, the next data write causes a lockout.
- R11: `rd_ok` is high exactly when `bus_ce_n` and `bus_oe_n` are low and `lockout` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Sampled bus address |
| bus_data | input | 8 | Sampled bus write data |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| arr_wr_en | output | 1 | One-clock grant of a byte write to the array |
| arr_wr_addr | output | ADDR_W | Address of the granted byte |
| arr_wr_data | output | 8 | Data of the granted byte |
| prot_on | output | 1 | Global protection flag |
| lockout | output | 1 | Device inaccessible after an illegal write |
| rd_ok | output | 1 | Read access permitted this cycle |

## Verification
A strobe is decided at the first clock edge that sees it released. The grant, the flag change or the start of `lockout` is therefore visible one clock after that edge. `rd_ok` follows the inputs within the same cycle. The bench keeps a behavioural model that is updated at each rising edge from the inputs present there. It compares every output 1 ns after that edge, while the inputs are still stable and the registered outputs have settled. Inputs only change at falling edges. The window and lockout lengths are counted in the model as integers, so an off-by-one in either duration shows up as a mismatch on a specific cycle.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_P1,
        ST_P2,
        ST_D3,
        ST_D4,
        ST_D5,
        ST_OPEN
    } wp_state_e;

    localparam logic [15:0] ARM_ADDR = 16'h5555;
    localparam logic [7:0]  ARM_DATA = 8'hA0;

    // Command step table: {address, data}. Step 2 is the disable branch;
    // the arm byte is compared separately.
    function automatic logic [23:0] cmd_entry(input logic [2:0] step);
        case (step)
            3'd0:    return {16'h5555, 8'hAA};
            3'd1:    return {16'h2AAA, 8'h55};
            3'd2:    return {16'h5555, 8'h80};
            3'd3:    return {16'h5555, 8'hAA};
            3'd4:    return {16'h2AAA, 8'h55};
            default: return {16'h5555, 8'h20};
        endcase
    endfunction

    function automatic logic [2:0] step_of(input wp_state_e st);
        case (st)
            ST_P1:   return 3'd1;
            ST_P2:   return 3'd2;
            ST_D3:   return 3'd3;
            ST_D4:   return 3'd4;
            ST_D5:   return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/wp_strobe_qual.sv
module wp_strobe_qual #(
    parameter int ADDR_W     = 17,
    parameter int GLITCH_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [7:0]        c_data
);
    localparam int CW = $clog2(GLITCH_MIN + 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] a;
        logic [7:0]        d;
    } qual_t;

    qual_t r_q, r_d;
    logic  active;

    always_comb begin
        active = ~ce_n & ~we_n & oe_n;
        r_d    = r_q;
        if (active) begin
            if (r_q.cnt != CW'(GLITCH_MIN)) r_d.cnt = r_q.cnt + CW'(1);
            r_d.a = addr;
            r_d.d = data;
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign commit = ~active & (r_q.cnt >= CW'(GLITCH_MIN));
    assign c_addr = r_q.a;
    assign c_data = r_q.d;
endmodule

// File: rtl/wp_cmd_match.sv
module wp_cmd_match #(
    parameter int ADDR_W = 17
) (
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              hit,
    output logic              hit_arm
);
    import wp_pkg::*;

    logic [23:0] ent;

    always_comb begin
        ent     = cmd_entry(step);
        hit     = (addr == ADDR_W'(ent[23:8])) && (data == ent[7:0]);
        hit_arm = (step == 3'd2) && (addr == ADDR_W'(ARM_ADDR)) && (data == ARM_DATA);
    end
endmodule

// File: rtl/wp_down_timer.sv
module wp_down_timer #(
    parameter int LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (start)            cnt_d = W'(LEN);
        else if (cnt_q != '0) cnt_d = cnt_q - W'(1);
        else                  cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard #(
    parameter int ADDR_W     = 17,
    parameter int GLITCH_MIN = 2,
    parameter int LOCK_CYC   = 60000,
    parameter int PAGE_WIN   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [7:0]        arr_wr_data,
    output logic              prot_on,
    output logic              lockout,
    output logic              rd_ok
);
    import wp_pkg::*;

    typedef struct packed {
        wp_state_e         st;
        logic              prot;
        logic              wr_en;
        logic [ADDR_W-1:0] wa;
        logic [7:0]        wd;
    } guard_t;

    guard_t            r_q, r_d;
    logic              commit;
    logic [ADDR_W-1:0] c_addr;
    logic [7:0]        c_data;
    logic              hit, hit_arm;
    logic              lock_go, lock_busy;
    logic              win_go, win_busy;
    logic              attempt;
    wp_state_e         eff_st;
    logic [2:0]        step;

    wp_strobe_qual #(.ADDR_W(ADDR_W), .GLITCH_MIN(GLITCH_MIN)) u_qual (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .data(bus_data),
        .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n),
        .commit(commit), .c_addr(c_addr), .c_data(c_data)
    );

    assign eff_st = (r_q.st == ST_OPEN && !win_busy) ? ST_IDLE : r_q.st;
    assign step   = step_of(eff_st);

    wp_cmd_match #(.ADDR_W(ADDR_W)) u_match (
        .step(step), .addr(c_addr), .data(c_data),
        .hit(hit), .hit_arm(hit_arm)
    );

    wp_down_timer #(.LEN(LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .start(lock_go), .busy(lock_busy)
    );

    wp_down_timer #(.LEN(PAGE_WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .start(win_go), .busy(win_busy)
    );

    always_comb begin
        r_d       = r_q;
        r_d.st    = eff_st;
        r_d.wr_en = 1'b0;
        lock_go   = 1'b0;
        win_go    = 1'b0;
        attempt   = 1'b0;
        if (commit && !lock_busy) begin
            case (eff_st)
                ST_IDLE: if (hit) r_d.st = ST_P1; else attempt = 1'b1;
                ST_P1:   if (hit) r_d.st = ST_P2; else attempt = 1'b1;
                ST_P2: begin
                    if (hit_arm) begin
                        r_d.prot = 1'b1;
                        r_d.st   = ST_OPEN;
                        win_go   = 1'b1;
                    end else if (hit) begin
                        r_d.st = ST_D3;
                    end else begin
                        attempt = 1'b1;
                    end
                end
                ST_D3:   if (hit) r_d.st = ST_D4; else attempt = 1'b1;
                ST_D4:   if (hit) r_d.st = ST_D5; else attempt = 1'b1;
                ST_D5: begin
                    if (hit) begin
                        r_d.prot = 1'b0;
                        r_d.st   = ST_IDLE;
                    end else begin
                        attempt = 1'b1;
                    end
                end
                ST_OPEN: begin
                    r_d.wr_en = 1'b1;
                    r_d.wa    = c_addr;
                    r_d.wd    = c_data;
                    win_go    = 1'b1;
                end
                default: attempt = 1'b1;
            endcase
            if (attempt) begin
                r_d.st = ST_IDLE;
                if (r_q.prot) begin
                    lock_go = 1'b1;
                end else begin
                    r_d.wr_en = 1'b1;
                    r_d.wa    = c_addr;
                    r_d.wd    = c_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.prot  <= 1'b0;
            r_q.wr_en <= 1'b0;
            r_q.wa    <= '0;
            r_q.wd    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign arr_wr_en   = r_q.wr_en;
    assign arr_wr_addr = r_q.wa;
    assign arr_wr_data = r_q.wd;
    assign prot_on     = r_q.prot;
    assign lockout     = lock_busy;
    assign rd_ok       = ~bus_ce_n & ~bus_oe_n & ~lock_busy;
endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk #(
    parameter int LOCK_CYC = 60000
) (
    input logic clk,
    input logic rst_n,
    input logic arr_wr_en,
    input logic prot_on,
    input logic lockout
);
    int   run_q;
    logic lock_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= 0;
            lock_prev_q <= 1'b0;
        end else begin
            lock_prev_q <= lockout;
            run_q       <= lockout ? run_q + 1 : 0;
            // R5
            if (lock_prev_q && !lockout) begin
                lock_len_chk: assert (run_q == LOCK_CYC);
            end
        end
    end

    // R2
    arm_not_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> !arr_wr_en);

    // R4
    disarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> (!arr_wr_en && !lockout));

    // R5
    lock_needs_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockout) |-> $past(prot_on));

    // R5
    no_grant_with_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_wr_en && lockout));

    // R6
    lock_freezes_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> $stable(prot_on));

    // R6
    no_grant_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> !$past(lockout));
endmodule

bind wp_seq_guard wp_seq_guard_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .arr_wr_en(arr_wr_en),
    .prot_on(prot_on), .lockout(lockout)
);

// File: tb/tb_wp_seq_guard.sv
`timescale 1ns/1ps
module tb_wp_seq_guard;
    localparam int AW = 17;
    localparam int GM = 2;
    localparam int LC = 40;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_data = '0;
    logic          bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
    logic          arr_wr_en, prot_on, lockout, rd_ok;
    logic [AW-1:0] arr_wr_addr;
    logic [7:0]    arr_wr_data;

    int checks = 0, fails = 0, perm_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wp_seq_guard #(.ADDR_W(AW), .GLITCH_MIN(GM), .LOCK_CYC(LC), .PAGE_WIN(PW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
        .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .prot_on(prot_on), .lockout(lockout), .rd_ok(rd_ok)
    );

    // behavioural reference model
    logic [15:0]   seq_a [6] = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
    logic [7:0]    seq_d [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
    int            m_cnt, m_prog, m_win, m_lock;
    bit            m_open, m_prot, m_wr, m_act, m_com, m_lk, m_wrs, m_lks;
    logic [AW-1:0] m_ca, m_wa;
    logic [7:0]    m_cd, m_wd;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_prog = 0; m_win = 0; m_lock = 0;
            m_open = 0; m_prot = 0; m_wr = 0; m_ca = '0; m_cd = '0;
        end else begin
            m_act = !bus_ce_n && !bus_we_n && bus_oe_n;
            m_com = !m_act && (m_cnt >= GM);
            m_lk  = (m_lock > 0);
            if (m_open && m_win == 0) m_open = 0;
            m_wr = 0; m_wrs = 0; m_lks = 0;
            if (m_com && !m_lk) begin
                if (m_open) begin
                    m_wr = 1; m_wa = m_ca; m_wd = m_cd; m_wrs = 1;
                end else if (m_prog == 2 && m_ca == AW'(16'h5555) && m_cd == 8'hA0) begin
                    m_prot = 1; m_open = 1; m_prog = 0; m_wrs = 1;
                end else if (m_ca == AW'(seq_a[m_prog]) && m_cd == seq_d[m_prog]) begin
                    if (m_prog == 5) begin m_prot = 0; m_prog = 0; end
                    else m_prog++;
                end else begin
                    m_prog = 0;
                    if (m_prot) m_lks = 1;
                    else begin m_wr = 1; m_wa = m_ca; m_wd = m_cd; end
                end
            end
            m_win  = m_wrs ? PW : (m_win > 0 ? m_win - 1 : 0);
            m_lock = m_lks ? LC : (m_lock > 0 ? m_lock - 1 : 0);
            if (m_act) begin m_cnt++; m_ca = bus_addr; m_cd = bus_data; end
            else m_cnt = 0;
            #1;
            if (arr_wr_en) perm_seen++;
            check("R3 grant", int'(arr_wr_en), int'(m_wr));
            if (m_wr) begin
                check("R3 grant addr", int'(arr_wr_addr), int'(m_wa));
                check("R3 grant data", int'(arr_wr_data), int'(m_wd));
            end
            check("R2/R4 prot_on", int'(prot_on), int'(m_prot));
            check("R5 lockout", int'(lockout), int'(m_lock > 0));
            check("R11 rd_ok", int'(rd_ok), int'(m_lock == 0 && !bus_ce_n && !bus_oe_n));
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int n,
                      input logic cel = 1'b0, input logic oel = 1'b1);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_ce_n = cel; bus_we_n = 1'b0; bus_oe_n = oel;
        repeat (n) @(negedge clk);
        bus_we_n = 1'b1; bus_ce_n = 1'b1; bus_oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic prefix();
        wr(AW'(16'h5555), 8'hAA, 3);
        wr(AW'(16'h2AAA), 8'h55, 3);
        wr(AW'(16'h5555), 8'hA0, 3);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int base;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check("R1 prot_on", int'(prot_on), 0);
        check("R1 lockout", int'(lockout), 0);
        check("R1 arr_wr_en", int'(arr_wr_en), 0);

        // R3 plain write while unprotected
        base = perm_seen; wr(17'h00123, 8'h5A, 3);
        check("R3 one grant", perm_seen - base, 1);

        // R9 glitch and boundary
        base = perm_seen; wr(17'h00200, 8'h01, 1);
        check("R9 short strobe ignored", perm_seen - base, 0);
        base = perm_seen; wr(17'h00201, 8'h02, GM);
        check("R9 minimum strobe accepted", perm_seen - base, 1);

        // R8 inhibit by oe_n low / ce_n high
        base = perm_seen; wr(17'h00300, 8'h03, 3, 1'b0, 1'b0);
        check("R8 oe_n low inhibits", perm_seen - base, 0);
        base = perm_seen; wr(17'h00301, 8'h04, 3, 1'b1, 1'b1);
        check("R8 ce_n high inhibits", perm_seen - base, 0);

        // R11 read access
        @(negedge clk); bus_ce_n = 1'b0; bus_oe_n = 1'b0;
        @(posedge clk); #1; check("R11 read allowed", int'(rd_ok), 1);
        @(negedge clk); bus_ce_n = 1'b1; bus_oe_n = 1'b1;

        // R2 arm and page-load
        base = perm_seen; prefix();
        check("R2 prot set", int'(prot_on), 1);
        wr(17'h10000, 8'hC3, 3);
        wr(17'h00007, 8'h3C, 3);
        check("R2 two page writes only", perm_seen - base, 2);

        // R10 window expiry then write -> lockout (R5)
        idle(PW + 8);
        base = perm_seen; wr(17'h00050, 8'h99, 3);
        check("R10 no grant after window", perm_seen - base, 0);
        check("R5 lockout raised", int'(lockout), 1);
        @(negedge clk); bus_ce_n = 1'b0; bus_oe_n = 1'b0;
        @(posedge clk); #1; check("R11 read refused in lockout", int'(rd_ok), 0);
        @(negedge clk); bus_ce_n = 1'b1; bus_oe_n = 1'b1;

        // R6 strobes during lockout do not advance the sequence
        wr(AW'(16'h5555), 8'hAA, 3);
        wr(AW'(16'h2AAA), 8'h55, 3);
        idle(LC + 5);
        check("R6 lockout expired", int'(lockout), 0);
        base = perm_seen; wr(AW'(16'h5555), 8'hA0, 3);
        check("R6 no progress kept, relocked", int'(lockout), 1);
        check("R6 no grant", perm_seen - base, 0);
        idle(LC + 5);

        // R2 prefix authorises write at any page
        base = perm_seen; prefix(); wr(17'h01F00, 8'h77, 3);
        check("R2 authorised write", perm_seen - base, 1);
        check("R2 still protected", int'(prot_on), 1);

        // R7 abort while protected
        idle(PW + 8);
        wr(AW'(16'h5555), 8'hAA, 3);
        base = perm_seen; wr(17'h00042, 8'h77, 3);
        check("R7 abort protected locks", int'(lockout), 1);
        check("R7 abort protected no grant", perm_seen - base, 0);
        idle(LC + 5);

        // R4 disable
        base = perm_seen;
        wr(AW'(16'h5555), 8'hAA, 3); wr(AW'(16'h2AAA), 8'h55, 3); wr(AW'(16'h5555), 8'h80, 3);
        wr(AW'(16'h5555), 8'hAA, 3); wr(AW'(16'h2AAA), 8'h55, 3); wr(AW'(16'h5555), 8'h20, 3);
        check("R4 prot cleared", int'(prot_on), 0);
        check("R4 command bytes not granted", perm_seen - base, 0);

        // R7 abort while unprotected
        wr(AW'(16'h5555), 8'hAA, 3);
        base = perm_seen; wr(17'h00100, 8'h11, 3);
        check("R7 abort unprotected grants", perm_seen - base, 1);

        idle(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule